// File: doc/BRIEF.md
# Baseline-Tracking Spike Detector

This block watches a stream of ADC codes and tracks a slowly moving reference level. The reference is the mean of the last 32 accepted samples. It is kept as a running sum: each new sample is added and the sample it displaces is subtracted. Once the window is full, every new sample is compared with the reference as it stood before that sample arrived. A deviation larger than a programmable code, in either direction, is reported as a spike together with its sign.

Each spike also produces a supply correction command. A sample that falls below the reference asks for a one-percent duty increase. A sample that rises above it asks for a one-percent decrease. Commands wait in a short circular queue. A free-running slot timer releases at most one command per slot, which is one millisecond at the default clock, to the duty-cycle adjuster downstream. The rest of the system normally ties the threshold to 2482, which is 2 V on a 3.3 V, 12-bit scale.

Top module: `spike_guard`

## Requirements
- R1: Window contents are zero after reset. In the cycle after an edge where `sampleValid` is high, `baseline` equals the sum of the last 32 accepted samples shifted right by 5. Without `sampleValid`, `baseline` holds its value.
- R2: No spike is flagged, and no command is queued, for any of the first 32 samples accepted after reset, whatever their values.
- R3: When `sampleIn - baseline > threshold`, using the baseline before the update, `spikeFlag` is high for exactly the next cycle with `spikeUp` = 1. A difference equal to the threshold is not a spike.
- R4: When `baseline - sampleIn > threshold`, `spikeFlag` is high for the next cycle with `spikeUp` = 0. A difference equal to the threshold is not a spike.
- R5: Every spike enqueues one command bit. The bit is 1 (raise duty) for a sample below the baseline and 0 (lower duty) for a sample above it. Commands leave the queue in arrival order.
- R6: The queue holds `QUEUE_DEPTH` (8) entries and `queueCount` reports its occupancy. A spike that arrives while the queue is full, judged before any pop at the same edge, is dropped and sets `overflow`. `overflow` stays high until reset.
- R7: An internal slot tick fires at the `TICK_CYCLES`-th rising edge after reset release and every `TICK_CYCLES` edges after that. On a tick edge with a non-empty queue, one entry is popped, and `stepValid` is high for the following cycle with the entry on `stepUp`. At no other time is `stepValid` high.
- R8: While `rstN` is low, `baseline`, `spikeFlag`, `stepValid`, `queueCount` and `overflow` are 0, and `queueEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Accept `sampleIn` at this edge |
| sampleIn | input | SAMPLE_W (12) | ADC code |
| threshold | input | SAMPLE_W (12) | Deviation limit code |
| baseline | output | SAMPLE_W (12) | Moving-average reference |
| spikeFlag | output | 1 | One-cycle spike indication |
| spikeUp | output | 1 | Spike sign, 1 = above baseline |
| stepValid | output | 1 | One-cycle command release |
| stepUp | output | 1 | Released command, 1 = raise duty |
| queueCount | output | clog2(QUEUE_DEPTH+1) | Queue occupancy |
| queueFull | output | 1 | Queue holds QUEUE_DEPTH entries |
| queueEmpty | output | 1 | Queue holds no entry |
| overflow | output | 1 | Sticky: a command was dropped |

## Verification
The bench builds the block with `TICK_CYCLES` = 20, the default window of 32 and a depth of 8. The short slot lets a burst of back-to-back spikes fill the queue and overflow it within one slot, and lets the queue drain across a few hundred cycles, so the full cycle of drop, sticky flag and in-order release is reached. The threshold is driven at its system value of 2482 to probe the equal-to-limit boundary in both directions. It is then lowered to 100 so that runs of alternating spikes produce a mixed command sequence.

// File: rtl/spike_guard_pkg.sv
package spike_guard_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;  // take sampleIn this edge
    logic armed;   // window full, comparisons allowed
  } dpStrobes_t;
endpackage

// File: rtl/spike_guard_dp.sv
module spike_guard_dp
  import spike_guard_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  output logic                hit,
  output logic                hitBelow,
  output logic [SAMPLE_W-1:0] baseline,
  output logic                spikeFlag,
  output logic                spikeUp
);
  localparam int WIN   = 1 << WIN_LOG2;
  localparam int SUM_W = SAMPLE_W + WIN_LOG2;

  logic [SAMPLE_W-1:0] winMem [WIN];
  logic [WIN_LOG2-1:0] wPtr;
  logic [SUM_W-1:0]    sum;
  logic                above;
  logic [SAMPLE_W-1:0] diffUp, diffDn;
  logic                hitAbove;

  assign baseline = sum[SUM_W-1:WIN_LOG2];
  assign above    = sampleIn > baseline;
  assign diffUp   = sampleIn - baseline;
  assign diffDn   = baseline - sampleIn;
  assign hitAbove = strobe.accept && strobe.armed && above && (diffUp > threshold);
  assign hitBelow = strobe.accept && strobe.armed && !above && (diffDn > threshold);
  assign hit      = hitAbove || hitBelow;

  for (genvar i = 0; i < WIN; i++) begin : gWin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) winMem[i] <= '0;
      else if (strobe.accept && wPtr == WIN_LOG2'(i)) winMem[i] <= sampleIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr      <= '0;
      sum       <= '0;
      spikeFlag <= 1'b0;
      spikeUp   <= 1'b0;
    end else begin
      spikeFlag <= hit;
      spikeUp   <= hitAbove;
      if (strobe.accept) begin
        wPtr <= wPtr + 1'b1;
        sum  <= sum + SUM_W'(sampleIn) - SUM_W'(winMem[wPtr]);
      end
    end
  end

  AST_NO_SPIKE_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    spikeFlag |-> $past(strobe.armed)); // R2
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.accept) |-> $stable(baseline)); // R1
  AST_UP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    spikeUp |-> spikeFlag); // R3
endmodule

// File: rtl/spike_guard_ctrl.sv
module spike_guard_ctrl
  import spike_guard_pkg::*;
#(
  parameter int WIN_LOG2    = 5,
  parameter int DEPTH       = 8,
  parameter int TICK_CYCLES = 50000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleValid,
  input  logic                         hit,
  input  logic                         hitBelow,
  output dpStrobes_t                   strobe,
  output logic                         stepValid,
  output logic                         stepUp,
  output logic [$clog2(DEPTH+1)-1:0]   qCount,
  output logic                         qFull,
  output logic                         qEmpty,
  output logic                         overflow
);
  localparam int WIN    = 1 << WIN_LOG2;
  localparam int FILL_W = WIN_LOG2 + 1;
  localparam int QAW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int TW     = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [FILL_W-1:0] fillCnt;
  logic [TW-1:0]     tickCnt;
  logic              tick;
  logic              qMem [DEPTH];
  logic [QAW-1:0]    wrPtr, rdPtr;
  logic              pushEn, popEn;

  assign strobe.accept = sampleValid;
  assign strobe.armed  = (fillCnt == FILL_W'(WIN));
  assign tick   = (tickCnt == TW'(TICK_CYCLES - 1));
  assign qFull  = (qCount == CNT_W'(DEPTH));
  assign qEmpty = (qCount == '0);
  assign pushEn = hit && !qFull;
  assign popEn  = tick && !qEmpty;

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qMem[i] <= 1'b0;
      else if (pushEn && wrPtr == QAW'(i)) qMem[i] <= hitBelow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt   <= '0;
      tickCnt   <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      qCount    <= '0;
      overflow  <= 1'b0;
      stepValid <= 1'b0;
      stepUp    <= 1'b0;
    end else begin
      if (sampleValid && !strobe.armed) fillCnt <= fillCnt + 1'b1;
      tickCnt   <= tick ? '0 : tickCnt + 1'b1;
      stepValid <= popEn;
      if (popEn) begin
        stepUp <= qMem[rdPtr];
        rdPtr  <= (rdPtr == QAW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      if (pushEn) wrPtr <= (wrPtr == QAW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (hit && qFull) overflow <= 1'b1;
      qCount <= qCount + CNT_W'(pushEn) - CNT_W'(popEn);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflow) |-> overflow); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && hit) |=> overflow); // R6
  AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(tick)); // R7
  AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> !stepValid); // R7
endmodule

// File: rtl/spike_guard.sv
module spike_guard
  import spike_guard_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int WIN_LOG2    = 5,
  parameter int QUEUE_DEPTH = 8,
  parameter int TICK_CYCLES = 50000
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic [SAMPLE_W-1:0]              sampleIn,
  input  logic [SAMPLE_W-1:0]              threshold,
  output logic [SAMPLE_W-1:0]              baseline,
  output logic                             spikeFlag,
  output logic                             spikeUp,
  output logic                             stepValid,
  output logic                             stepUp,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0] queueCount,
  output logic                             queueFull,
  output logic                             queueEmpty,
  output logic                             overflow
);
  dpStrobes_t strobe;
  logic       hit, hitBelow;

  spike_guard_ctrl #(
    .WIN_LOG2(WIN_LOG2), .DEPTH(QUEUE_DEPTH), .TICK_CYCLES(TICK_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .hit(hit),
    .hitBelow(hitBelow), .strobe(strobe), .stepValid(stepValid),
    .stepUp(stepUp), .qCount(queueCount), .qFull(queueFull),
    .qEmpty(queueEmpty), .overflow(overflow)
  );

  spike_guard_dp #(
    .SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .threshold(threshold), .hit(hit), .hitBelow(hitBelow),
    .baseline(baseline), .spikeFlag(spikeFlag), .spikeUp(spikeUp)
  );
endmodule

// File: tb/spike_guard_test.sv
`timescale 1ns/1ps
module spike_guard_test;
  localparam int TICK  = 20;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [11:0] threshold = 12'd2482;
  logic [11:0] baseline;
  logic        spikeFlag, spikeUp, stepValid, stepUp;
  logic [3:0]  queueCount;
  logic        queueFull, queueEmpty, overflow;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // reference model state
  int mWin[32];
  int mSum = 0, mPtr = 0, mFill = 0, mCyc = 0;
  bit mFlag = 0, mUp = 0, mOvf = 0;
  bit mQ[$];
  bit expQ[$];  // scoreboard of released commands

  spike_guard #(.QUEUE_DEPTH(DEPTH), .TICK_CYCLES(TICK)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .threshold(threshold), .baseline(baseline), .spikeFlag(spikeFlag),
    .spikeUp(spikeUp), .stepValid(stepValid), .stepUp(stepUp),
    .queueCount(queueCount), .queueFull(queueFull), .queueEmpty(queueEmpty),
    .overflow(overflow)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: evaluates each rising edge from bench-driven inputs
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mWin[i]) mWin[i] = 0;
      mSum = 0; mPtr = 0; mFill = 0; mCyc = 0;
      mFlag = 0; mUp = 0; mOvf = 0;
      mQ.delete(); expQ.delete();
    end else begin
      bit tick, hit, up, full;
      int base, s;
      tick = (mCyc == TICK - 1);
      mCyc = tick ? 0 : mCyc + 1;
      hit = 0; up = 0;
      if (sampleValid) begin
        s = int'(sampleIn);
        base = mSum >> 5;
        if (mFill == 32) begin
          if (s > base && s - base > int'(threshold)) begin hit = 1; up = 1; end
          else if (base > s && base - s > int'(threshold)) hit = 1;
        end
        mSum = mSum + s - mWin[mPtr];
        mWin[mPtr] = s;
        mPtr = (mPtr + 1) % 32;
        if (mFill < 32) mFill++;
      end
      mFlag = hit; mUp = up;
      full = (mQ.size() == DEPTH);
      if (tick && mQ.size() > 0) expQ.push_back(mQ.pop_front());
      if (hit) begin
        if (!full) mQ.push_back(!up);
        else mOvf = 1;
      end
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(baseline == 12'(mSum >> 5), "R1 baseline", int'(baseline), mSum >> 5);
      if (mFill < 32 || mFlag == 0)
        check(spikeFlag == mFlag, "R2 spikeFlag", int'(spikeFlag), int'(mFlag));
      else if (mUp)
        check(spikeFlag && spikeUp, "R3 spike above", int'({spikeFlag, spikeUp}), 3);
      else
        check(spikeFlag && !spikeUp, "R4 spike below", int'({spikeFlag, spikeUp}), 2);
      check(int'(queueCount) == mQ.size(), "R6 queueCount", int'(queueCount), mQ.size());
      check(overflow == mOvf, "R6 overflow", int'(overflow), int'(mOvf));
      check(queueFull == (mQ.size() == DEPTH), "R6 queueFull", int'(queueFull), int'(mQ.size() == DEPTH));
      if (stepValid) begin
        if (expQ.size() == 0) check(0, "R7 unexpected stepValid", 1, 0);
        else begin
          bit e;
          e = expQ.pop_front();
          check(stepUp == e, "R5 command order", int'(stepUp), int'(e));
        end
      end else if (expQ.size() > 0) begin
        check(0, "R7 missing stepValid", 0, 1);
        void'(expQ.pop_front());
      end
    end
  end

  // driver: called at a falling edge, returns at the next one
  task automatic send(input int v);
    sampleValid = 1'b1;
    sampleIn = 12'(v);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic idle(input int n);
    sampleValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(baseline == 0 && !spikeFlag && !stepValid, "R8 reset outputs", int'(baseline), 0);
    check(queueCount == 0 && queueEmpty && !overflow, "R8 reset queue", int'(queueCount), 0);
    rstN = 1'b1;
    // R2: wild samples while filling
    for (int i = 0; i < 32; i++) send((i % 2) ? 4095 : 0);
    check(queueEmpty, "R2 no command while filling", int'(queueCount), 0);
    idle(3);
    // R1: settle baseline at 500 with gaps
    for (int i = 0; i < 32; i++) begin send(500); if (i % 5 == 0) idle(1); end
    check(baseline == 12'd500, "R1 settled baseline", int'(baseline), 500);
    // R3 boundary: equal then above
    send(500 + 2482);
    idle(2);
    for (int i = 0; i < 32; i++) send(500);
    send(500 + 2483);
    idle(2);
    // R4 boundary at baseline 3500
    for (int i = 0; i < 32; i++) send(3500);
    send(3500 - 2482);
    send(3500 - 2483);
    idle(2);
    idle(3 * TICK);
    // R6 overflow burst with a low threshold, mixed signs for R5 order
    for (int i = 0; i < 32; i++) send(2000);
    threshold = 12'd100;
    for (int i = 0; i < 14; i++) send((i % 2) ? 3000 : 1000);
    idle(2);
    check(overflow, "R6 overflow set", int'(overflow), 1);
    // R7 drain, R6 sticky
    idle(12 * TICK);
    check(queueEmpty && overflow, "R6 sticky after drain", int'(overflow), 1);
    check(!stepValid, "R7 quiet when empty", int'(stepValid), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule